// File: doc/BRIEF.md
# Table-Sequenced Halfband Decimator

This block halves the rate of a real, signed sample stream with a halfband FIR whose multiply-accumulate schedule is taken from a small table written at run time. A settings port with a strobe, an 8-bit address and a 32-bit data word loads the symmetric tap coefficients and the schedule entries. Each step of the schedule names two history taps to pre-add, a coefficient to multiply the sum by, a center tap, and flags that start, extend or hold the running sum, end the sequence, or emit a result.

Samples enter with `smp_stb_i`. Every second accepted sample starts a sequence that executes the schedule from entry 8 down to entry 0, one entry per clock, against a history snapshot fixed at the triggering sample. Results are rounded, saturated to 18 bits and presented with a one-cycle `smp_stb_o`. Input strobes must be at least 5 clocks apart. A trigger that arrives while a sequence is still running is dropped.

Top module: `hbd_filter`

## Requirements
- R1: A settings write to address 124 stores data bits [17:0] as a signed coefficient into the slot chosen by a coefficient pointer. The pointer then advances and wraps from 7 back to 0. Reset clears it to 0.
- R2: A settings write to address 125 stores data bits [19:0] into the schedule entry chosen by an entry pointer. The pointer advances and wraps from 8 back to 0. The bit layout is: [19] emit result, [18] accumulate, [17] load, [16] done, [15:12] center tap index, [11:8] first pair index, [7:4] second pair index, [3:0] coefficient select (low 3 bits used).
- R3: A settings write to any other address changes no coefficient, no entry and no pointer.
- R4: Every accepted sample is stored. A history index h reads the sample accepted h strobes before the triggering sample, with index 0 being the triggering sample itself. Samples accepted while a sequence runs do not change the values it reads.
- R5: Only the 2nd, 4th, 6th, ... sample accepted since reset starts a sequence.
- R6: A sequence executes entries 8, 7, ... 0, one per clock, starting on the edge after the triggering edge. It stops after the first entry that has the done bit set, or after entry 0.
- R7: Each executed entry forms p = coef[c] * (x[a] + x[b]). With load set, the sum becomes x[e]*2^15 + p. Otherwise, with accumulate set, the sum becomes sum + p. With neither set, the sum is unchanged.
- R8: If the entry with the emit bit set is the n-th entry executed, `smp_stb_o` is high for exactly the one cycle after the (n+1)-th rising edge that follows the triggering edge. A sequence with no emit bit produces no output strobe.
- R9: The output value is floor((sum + 2^15) / 2^16), saturated to the range -131072 to 131071.
- R10: While reset is asserted, `smp_o` is 0, `smp_stb_o` is 0, and the history, coefficients, schedule and parity are cleared.
- R11: `smp_o` keeps its value in every cycle in which `smp_stb_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_stb_i | input | 1 | Settings write strobe |
| cfg_addr_i | input | 8 | Settings address |
| cfg_data_i | input | 32 | Settings data |
| smp_i | input | 17 | Signed input sample |
| smp_stb_i | input | 1 | Input sample valid |
| smp_o | output | 18 | Signed filtered output |
| smp_stb_o | output | 1 | Output sample valid, one cycle |

## Verification
The assertions check the sequencer on every cycle. They confirm that a qualifying strobe starts a sequence at entry 8, that the entry index counts down and stops at entry 0, that the parity flips on every accepted sample, that the running sum only moves while a sequence runs, and that the output holds between strobes. The arithmetic needs the bench scenarios: pair pre-add, centre-tap scaling, rounding, saturation, per-entry output timing, and the effect of run-time schedule variants such as early done, two results per sequence or no result. The same applies to pointer wraparound, ignored addresses and parity recovery after a mid-stream reset. In those scenarios the reference model predicts the output of every cycle.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int TAP_AW = 4;

  typedef struct packed {
    logic              emit;
    logic              accum;
    logic              load;
    logic              done;
    logic [TAP_AW-1:0] ctr_a;
    logic [TAP_AW-1:0] pair_a;
    logic [TAP_AW-1:0] pair_b;
    logic [TAP_AW-1:0] coef_a;
  } step_t;

  localparam int STEP_W = $bits(step_t);
endpackage

// File: rtl/hbd_cfg_mem.sv
module hbd_cfg_mem
  import hbd_pkg::*;
#(
  parameter int COEF_W    = 18,
  parameter int N_COEF    = 8,
  parameter int N_STEP    = 9,
  parameter int ADDR_COEF = 124,
  parameter int ADDR_STEP = 125,
  localparam int CIDX_W   = $clog2(N_COEF),
  localparam int SIDX_W   = $clog2(N_STEP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_stb_i,
  input  logic [7:0]               cfg_addr_i,
  input  logic [31:0]              cfg_data_i,
  input  logic [SIDX_W-1:0]        step_sel_i,
  input  logic [TAP_AW-1:0]        coef_sel_i,
  output step_t                    step_o,
  output logic signed [COEF_W-1:0] coef_o
);
  logic                     coef_we, step_we;
  logic [CIDX_W-1:0]        cptr_q;
  logic [SIDX_W-1:0]        sptr_q;
  logic signed [COEF_W-1:0] coef_q [N_COEF];
  step_t                    step_q [N_STEP];
  logic                     unused_bits;

  assign coef_we     = cfg_stb_i && (cfg_addr_i == 8'(ADDR_COEF));
  assign step_we     = cfg_stb_i && (cfg_addr_i == 8'(ADDR_STEP));
  assign unused_bits = ^{cfg_data_i[31:STEP_W], coef_sel_i[TAP_AW-1:CIDX_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cptr_q <= '0;
      sptr_q <= '0;
    end else begin
      if (coef_we) cptr_q <= (cptr_q == CIDX_W'(N_COEF-1)) ? '0 : cptr_q + 1'b1;
      if (step_we) sptr_q <= (sptr_q == SIDX_W'(N_STEP-1)) ? '0 : sptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_COEF; i++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 coef_q[i] <= '0;
      else if (coef_we && cptr_q == CIDX_W'(i))    coef_q[i] <= cfg_data_i[COEF_W-1:0];
    end
  end

  for (genvar i = 0; i < N_STEP; i++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 step_q[i] <= '0;
      else if (step_we && sptr_q == SIDX_W'(i))    step_q[i] <= step_t'(cfg_data_i[STEP_W-1:0]);
    end
  end

  assign step_o = step_q[step_sel_i];
  assign coef_o = coef_q[coef_sel_i[CIDX_W-1:0]];
endmodule

// File: rtl/hbd_hist.sv
module hbd_hist #(
  parameter int SMP_W  = 17,
  parameter int DEPTH  = 32,
  parameter int TAP_AW = 4,
  parameter int NRD    = 3,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic signed [SMP_W-1:0] wr_data_i,
  output logic [PTR_W-1:0]        wr_ptr_o,
  input  logic [PTR_W-1:0]        base_i,
  input  logic [TAP_AW-1:0]       rel_i [NRD],
  output logic signed [SMP_W-1:0] rd_o  [NRD]
);
  logic [PTR_W-1:0]        ptr_q;
  logic signed [SMP_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (wr_i) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[i] <= '0;
      else if (wr_i && ptr_q == PTR_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  // index 0 is the slot written by the triggering sample
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_o[g] = mem_q[base_i - PTR_W'(rel_i[g])];
  end

  assign wr_ptr_o = ptr_q;
endmodule

// File: rtl/hbd_mac.sv
module hbd_mac #(
  parameter int SMP_W     = 17,
  parameter int COEF_W    = 18,
  parameter int ACC_W     = 40,
  parameter int OUT_W     = 18,
  parameter int CTR_SHIFT = 15,
  parameter int OUT_SHIFT = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     load_i,
  input  logic                     accum_i,
  input  logic signed [SMP_W-1:0]  xa_i,
  input  logic signed [SMP_W-1:0]  xb_i,
  input  logic signed [SMP_W-1:0]  xc_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic signed [OUT_W-1:0]  rnd_o
);
  localparam int PS_W = SMP_W + 1;
  localparam int PR_W = PS_W + COEF_W;
  localparam int RW   = ACC_W + 1;
  localparam logic signed [RW-1:0] RND  = RW'(1) << (OUT_SHIFT - 1);
  localparam logic signed [RW-1:0] MAXV = RW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [RW-1:0] MINV = ~MAXV;

  logic signed [PS_W-1:0]  psum;
  logic signed [PR_W-1:0]  prod;
  logic signed [ACC_W-1:0] prod_x, ctr_x, acc_q;
  logic signed [RW-1:0]    rsum, rshift;

  assign psum   = {xa_i[SMP_W-1], xa_i} + {xb_i[SMP_W-1], xb_i};
  assign prod   = psum * coef_i;
  assign prod_x = ACC_W'(prod);
  assign ctr_x  = ACC_W'(xc_i) <<< CTR_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (en_i) begin
      if (load_i)       acc_q <= ctr_x + prod_x;
      else if (accum_i) acc_q <= acc_q + prod_x;
    end
  end

  assign rsum   = RW'(acc_q) + RND;
  assign rshift = rsum >>> OUT_SHIFT;

  always_comb begin
    if (rshift > MAXV)      rnd_o = MAXV[OUT_W-1:0];
    else if (rshift < MINV) rnd_o = MINV[OUT_W-1:0];
    else                    rnd_o = rshift[OUT_W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/hbd_filter.sv
module hbd_filter
  import hbd_pkg::*;
#(
  parameter int SMP_W      = 17,
  parameter int COEF_W     = 18,
  parameter int ACC_W      = 40,
  parameter int OUT_W      = 18,
  parameter int N_COEF     = 8,
  parameter int N_STEP     = 9,
  parameter int HIST_DEPTH = 32,
  parameter int ADDR_COEF  = 124,
  parameter int ADDR_STEP  = 125,
  parameter int CTR_SHIFT  = 15,
  parameter int OUT_SHIFT  = 16,
  localparam int SIDX_W    = $clog2(N_STEP),
  localparam int PTR_W     = $clog2(HIST_DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_stb_i,
  input  logic [7:0]              cfg_addr_i,
  input  logic [31:0]             cfg_data_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    smp_stb_i,
  output logic signed [OUT_W-1:0] smp_o,
  output logic                    smp_stb_o
);
  logic                     par_q, busy_q, out_pend_q, trig;
  logic [SIDX_W-1:0]        ph_q;
  logic [PTR_W-1:0]         base_q, wr_ptr;
  step_t                    step;
  logic signed [COEF_W-1:0] coef;
  logic [TAP_AW-1:0]        rel [3];
  logic signed [SMP_W-1:0]  tap [3];
  logic signed [ACC_W-1:0]  acc;
  logic signed [OUT_W-1:0]  rnd;

  assign trig = smp_stb_i && par_q && !busy_q;

  hbd_cfg_mem #(
    .COEF_W(COEF_W), .N_COEF(N_COEF), .N_STEP(N_STEP),
    .ADDR_COEF(ADDR_COEF), .ADDR_STEP(ADDR_STEP)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_stb_i, .cfg_addr_i, .cfg_data_i,
    .step_sel_i(ph_q), .coef_sel_i(step.coef_a),
    .step_o(step), .coef_o(coef)
  );

  assign rel[0] = step.pair_a;
  assign rel[1] = step.pair_b;
  assign rel[2] = step.ctr_a;

  hbd_hist #(
    .SMP_W(SMP_W), .DEPTH(HIST_DEPTH), .TAP_AW(TAP_AW), .NRD(3)
  ) u_hist (
    .clk_i, .rst_ni, .wr_i(smp_stb_i), .wr_data_i(smp_i),
    .wr_ptr_o(wr_ptr), .base_i(base_q), .rel_i(rel), .rd_o(tap)
  );

  hbd_mac #(
    .SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
    .CTR_SHIFT(CTR_SHIFT), .OUT_SHIFT(OUT_SHIFT)
  ) u_mac (
    .clk_i, .rst_ni, .en_i(busy_q), .load_i(step.load), .accum_i(step.accum),
    .xa_i(tap[0]), .xb_i(tap[1]), .xc_i(tap[2]), .coef_i(coef),
    .acc_o(acc), .rnd_o(rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q      <= 1'b0;
      busy_q     <= 1'b0;
      ph_q       <= '0;
      base_q     <= '0;
      out_pend_q <= 1'b0;
    end else begin
      if (smp_stb_i) par_q <= !par_q;
      out_pend_q <= busy_q && step.emit;
      if (trig) begin
        busy_q <= 1'b1;
        ph_q   <= SIDX_W'(N_STEP - 1);
        base_q <= wr_ptr;
      end else if (busy_q) begin
        if (step.done || ph_q == '0) busy_q <= 1'b0;
        else                         ph_q   <= ph_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o     <= '0;
      smp_stb_o <= 1'b0;
    end else begin
      smp_stb_o <= out_pend_q;
      if (out_pend_q) smp_o <= rnd;
    end
  end
endmodule

// File: rtl/hbd_filter_chk.sv
module hbd_filter_chk #(
  parameter int N_STEP = 9,
  parameter int SIDX_W = 4,
  parameter int OUT_W  = 18,
  parameter int ACC_W  = 40
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_stb_i,
  input logic                    smp_stb_o,
  input logic signed [OUT_W-1:0] smp_o,
  input logic                    par_q,
  input logic                    busy_q,
  input logic [SIDX_W-1:0]       ph_q,
  input logic                    step_done,
  input logic                    out_pend_q,
  input logic signed [ACC_W-1:0] acc
);
  a_r6_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && par_q && !busy_q) |=> (busy_q && ph_q == SIDX_W'(N_STEP - 1)));

  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !step_done && ph_q != '0) |=> (busy_q && ph_q == $past(ph_q) - 1'b1));

  a_r6_stop_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ph_q == '0 && !(smp_stb_i && par_q)) |=> !busy_q);

  a_r5_parity_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i |=> (par_q != $past(par_q)));

  a_r7_acc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(acc));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_pend_q |=> ($stable(smp_o) && !smp_stb_o));

  a_r8_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_stb_o) |-> $past(busy_q, 2));
endmodule

bind hbd_filter hbd_filter_chk #(
  .N_STEP(N_STEP), .SIDX_W(SIDX_W), .OUT_W(OUT_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_stb_i(smp_stb_i), .smp_stb_o(smp_stb_o),
  .smp_o(smp_o), .par_q(par_q), .busy_q(busy_q), .ph_q(ph_q),
  .step_done(step.done), .out_pend_q(out_pend_q), .acc(acc)
);

// File: tb/hbd_filter_tb.sv
module hbd_filter_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_stb_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic signed [16:0] smp_i = '0;
  logic smp_stb_i = 1'b0;
  logic signed [17:0] smp_o;
  logic smp_stb_o;

  always #5 clk_i = ~clk_i;

  hbd_filter u_dut (.*);

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  bit done_flag = 1'b0;

  // behavioural reference state
  longint m_coef [8];
  int     m_tbl  [9];
  int     m_cp, m_tp;
  longint m_hist [32];
  bit     m_par;
  longint q_due [$];
  longint q_val [$];
  longint last_out;

  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    foreach (m_coef[i]) m_coef[i] = 0;
    foreach (m_tbl[i])  m_tbl[i]  = 0;
    foreach (m_hist[i]) m_hist[i] = 0;
    m_cp = 0; m_tp = 0; m_par = 0; last_out = 0;
    q_due.delete(); q_val.delete();
  endtask

  function automatic longint round_sat(input longint a);
    longint r;
    r = (a + 32768) >>> 16;
    if (r > 131071)  r = 131071;
    if (r < -131072) r = -131072;
    return r;
  endfunction

  // walk the schedule from entry 8 down to 0 on the snapshot
  task automatic predict(input longint e0);
    longint acc = 0, p;
    int n = 0;
    for (int i = 8; i >= 0; i--) begin
      int w = m_tbl[i];
      n++;
      p = m_coef[w & 7] * (m_hist[(w >> 8) & 15] + m_hist[(w >> 4) & 15]);
      if ((w >> 17) & 1)      acc = m_hist[(w >> 12) & 15] * 32768 + p;
      else if ((w >> 18) & 1) acc = acc + p;
      if ((w >> 19) & 1) begin
        q_due.push_back(e0 + n + 1);
        q_val.push_back(round_sat(acc));
      end
      if ((w >> 16) & 1) break;
    end
  endtask

  task automatic cfg_wr(input int addr, input logic [31:0] data);
    @(negedge clk_i);
    cfg_stb_i = 1'b1; cfg_addr_i = addr[7:0]; cfg_data_i = data;
    if (addr == 124) begin
      m_coef[m_cp] = longint'($signed(data[17:0])); m_cp = (m_cp + 1) % 8;
    end else if (addr == 125) begin
      m_tbl[m_tp] = int'(data[19:0]); m_tp = (m_tp + 1) % 9;
    end
    @(negedge clk_i);
    cfg_stb_i = 1'b0;
  endtask

  task automatic send(input int val, input int gap);
    @(negedge clk_i);
    smp_stb_i = 1'b1; smp_i = val[16:0];
    for (int i = 31; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = longint'($signed(val[16:0]));
    if (m_par) predict(cyc + 1);
    m_par = !m_par;
    @(negedge clk_i);
    smp_stb_i = 1'b0;
    repeat (gap - 2) @(negedge clk_i);
  endtask

  function automatic logic [31:0] ent(input bit em, input bit ac, input bit ld, input bit dn,
                                      input int e, input int a, input int b, input int c);
    return {12'd0, em, ac, ld, dn, e[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction

  task automatic load_coefs_std();
    cfg_wr(124, -32'sd49);    cfg_wr(124, 32'sd165);
    cfg_wr(124, -32'sd412);
    cfg_wr(126, 32'h0003_ffff); // R3: ignored address
    cfg_wr(123, 32'h0001_2345); // R3: ignored address
    cfg_wr(124, 32'sd873);    cfg_wr(124, -32'sd1681);
    cfg_wr(124, 32'sd3135);   cfg_wr(124, -32'sd6282);
    cfg_wr(124, 32'sd20628);
  endtask

  // full schedule: entry 8 loads, 7..1 accumulate, 0 holds and emits
  task automatic load_tbl_full();
    cfg_wr(125, ent(1, 0, 0, 1, 15, 0, 0, 0));
    for (int i = 1; i <= 7; i++) cfg_wr(125, ent(0, 1, 0, 0, 15, 15 - (8 - i), 8 - i, 8 - i));
    cfg_wr(125, ent(0, 0, 1, 0, 15, 15, 0, 0));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_clear();
    repeat (2) @(negedge clk_i);
    chk(smp_o == 0, "R10 output in reset", longint'(smp_o), 0);
    chk(smp_stb_o == 0, "R10 strobe in reset", longint'(smp_stb_o), 0);
    rst_ni = 1'b1;
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      bit exp_stb;
      exp_stb = (q_due.size() > 0) && (q_due[0] == cyc);
      chk(smp_stb_o == exp_stb, "R8 output strobe", longint'(smp_stb_o), longint'(exp_stb));
      if (exp_stb) begin
        chk(longint'(smp_o) == q_val[0], "R7 R9 output value", longint'(smp_o), q_val[0]);
        last_out = q_val[0];
        void'(q_due.pop_front()); void'(q_val.pop_front());
      end else begin
        chk(longint'(smp_o) == last_out, "R11 output hold", longint'(smp_o), last_out);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R6 watchdog act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R1 R2 R3: coefficients with stray writes, full schedule
    load_coefs_std();
    load_tbl_full();

    // R4 R5 R6: impulse, then step, then random with varied spacing
    send(1000, 5);
    repeat (20) send(0, 5);
    repeat (40) send(30000, 5);
    repeat (40) send($urandom_range(0, 131071) - 65536, 5 + $urandom_range(0, 3));

    // R6 R8: early done at entry 4, emit also at entry 6
    cfg_wr(125, ent(0, 1, 0, 0, 15, 8, 7, 7));
    cfg_wr(125, ent(0, 1, 0, 0, 15, 9, 6, 6));
    cfg_wr(125, ent(0, 1, 0, 0, 15, 10, 5, 5));
    cfg_wr(125, ent(0, 1, 0, 0, 15, 11, 4, 4));
    cfg_wr(125, ent(1, 1, 0, 1, 15, 12, 3, 3));
    cfg_wr(125, ent(0, 1, 0, 0, 15, 13, 2, 2));
    cfg_wr(125, ent(1, 1, 0, 0, 15, 14, 1, 1));
    cfg_wr(125, ent(0, 1, 0, 0, 15, 15, 0, 0));
    cfg_wr(125, ent(0, 0, 1, 0, 3, 1, 2, 0));
    repeat (30) send($urandom_range(0, 131071) - 65536, 5 + $urandom_range(0, 2));

    // R8: no emit bit anywhere, no output
    for (int i = 0; i < 9; i++) cfg_wr(125, ent(0, 1, (i == 8), (i == 0), 15, i, 15 - i, i));
    repeat (12) send($urandom_range(0, 131071) - 65536, 6);

    // R1 wrap and R9 saturation: ten coefficient writes, slots 0 and 1 overwritten
    cfg_wr(124, 32'sd5);
    cfg_wr(124, 32'sd7);
    for (int i = 0; i < 8; i++) cfg_wr(124, (i % 2) ? 32'sd131071 : 32'sd120000);
    load_tbl_full();
    repeat (10) send(65535, 5);
    repeat (10) send(-65536, 5);
    repeat (10) send((($urandom_range(0, 1)) ? 65535 : -65536), 5);

    // R5 R10: reset after an odd sample, parity restarts at even
    send(4321, 5);
    do_reset();
    chk(smp_o == 0, "R10 output after reset", longint'(smp_o), 0);
    load_coefs_std();
    load_tbl_full();
    send(-20000, 7);
    repeat (12) @(negedge clk_i);
    chk(smp_stb_o == 0 && q_due.size() == 0, "R5 first sample no output",
        longint'(smp_stb_o), 0);
    repeat (24) send($urandom_range(0, 131071) - 65536, 5);

    repeat (30) @(negedge clk_i);
    chk(q_due.size() == 0, "R8 all results seen", q_due.size(), 0);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule